// File: doc/BRIEF.md
# SPI Slave Serializer

This block is the receive and transmit datapath of an SPI peripheral when it acts as a slave. It runs entirely on the system clock. The external serial clock, select and data-in lines pass through two-flop synchronisers. The synchronised serial clock is then edge-detected, so that every shift, capture and load is an ordinary clocked event. A word is framed by the active-low select. Incoming bits are shifted in MSB first, while the data-out line is driven from a serializer that is loaded from a transmit holding register.

When the last bit of a word has been captured, the word is placed in a receive register and a receive-full flag is raised. If that register is loaded again before software has read it, an overrun flag is raised. The clock polarity, the clock phase and the word length (8 to 16 bits) come from a single configuration set, which is held static while the select is active. Pin-to-action latency is three system clocks, so the serial clock's high and low times must each exceed two system-clock periods.

Top module: `spi_slv_serdes`

## Requirements
- R1: After reset rx_full_o=0, rx_ovr_o=0, tx_empty_o=1, miso_oen_o=1 and rx_data_o=0.
- R2: sck_i, nss_i and mosi_i each pass through a two-flop synchroniser. A serial-clock edge is acted on only while the synchronised select is low. Edges seen while the select is high change no state.
- R3: The word length is 8 + cfg_bits_i for codes 0 to 8. Codes 9 to 15 give 16 bits. Both directions run MSB first. rx_data_o is right-justified and its unused upper bits are zero.
- R4: A leading edge is a transition of the serial clock away from cfg_cpol_i. With cfg_ncpha_i=1, data is captured on leading edges and changed on trailing edges. With cfg_ncpha_i=0, data is changed on leading edges and captured on trailing edges. The serializer MSB is valid on miso_o from the moment it is loaded.
- R5: When a word completes, it is written to rx_data_o and rx_full_o is set. A pulse on rx_rd_i clears rx_full_o.
- R6: A word completing while rx_full_o=1 sets rx_ovr_o, unless rx_rd_i is high in that same cycle. In that case rx_full_o stays 1 and no overrun is flagged. ovr_clr_i clears rx_ovr_o.
- R7: tx_wr_i writes tx_data_i into the holding register and clears tx_empty_o. The holding register is copied into the serializer on the falling edge of the select and at every completed word; this copy sets tx_empty_o. If nothing new was written, the old holding contents are sent again.
- R8: If the select rises in the middle of a word, the partial word is dropped and the bit counter returns to zero. rx_full_o is not set.
- R9: miso_oen_o (active low) is 0 exactly while the synchronised select is low. miso_o carries the serializer bit at position word length − 1.
- R10: With the select held low, words follow each other back to back. Each new word is sent from the holding contents present when the previous word completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the external master |
| nss_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oen_o | output | 1 | Output enable for the data-out pad, active low |
| cfg_cpol_i | input | 1 | Idle level of the serial clock |
| cfg_ncpha_i | input | 1 | 1: capture on leading edge; 0: capture on trailing edge |
| cfg_bits_i | input | 4 | Word-length code |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | MAX_BITS (16) | Transmit word, right-justified |
| tx_empty_o | output | 1 | Holding register has been copied into the serializer |
| rx_rd_i | input | 1 | Read strobe for the receive register |
| rx_data_o | output | MAX_BITS (16) | Last received word |
| rx_full_o | output | 1 | Unread word present |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rx_ovr_o | output | 1 | Overrun flag |

## Verification
The cycle that matters most is the one where a word completes in the same clock as a read of the receive register. There, the load must win for rx_full_o, and no overrun may be flagged even though an unread word was present. The bench provokes this case from the pins. An unread word is left in place. The read strobe is then placed exactly on the clock in which the final capture edge reaches the register: two falling clock edges after the last serial-clock toggle. The bench then judges rx_full_o=1, rx_ovr_o=0 and the new rx_data_o. A matching plain overrun case, with no read strobe, shows that the flag is set when the read does not coincide.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic capture;   // sample mosi
    logic change;    // advance miso
    logic sel_fall;  // select just asserted
  } spi_edge_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sck_s_i,
  input  logic      nss_s_i,
  input  logic      cpol_i,
  input  logic      ncpha_i,
  output spi_edge_t ev_o
);

  logic sck_q, nss_q;
  logic toggled, leading, trailing, selected;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      nss_q <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      nss_q <= nss_s_i;
    end
  end

  always_comb begin
    toggled     = sck_s_i ^ sck_q;
    leading     = toggled & (sck_s_i ^ cpol_i);
    trailing    = toggled & ~(sck_s_i ^ cpol_i);
    selected    = ~nss_s_i;
    ev_o.capture  = selected & (ncpha_i ? leading : trailing);
    ev_o.change   = selected & (ncpha_i ? trailing : leading);
    ev_o.sel_fall = nss_q & ~nss_s_i;
  end

  // pulse width > 2 clocks: an edge is never followed by another in the next cycle
  AST_EDGE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o.capture || ev_o.change) |=> !(ev_o.capture || ev_o.change)); // R4

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int unsigned MAX_BITS = 16,
  localparam int unsigned CNT_W = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nss_s_i,
  input  logic                mosi_s_i,
  input  spi_edge_t           ev_i,
  input  logic [CNT_W-1:0]    nbits_i,
  input  logic [MAX_BITS-1:0] tx_hold_i,
  output logic                miso_o,
  output logic                tx_copy_o,
  output logic                rx_load_o,
  output logic [MAX_BITS-1:0] rx_word_o
);

  logic [CNT_W-1:0]    bit_cnt;
  logic [MAX_BITS-2:0] rx_sh;
  logic [MAX_BITS-1:0] tx_sh;
  logic [MAX_BITS-1:0] rx_next, len_mask;
  logic                last_bit;

  always_comb begin
    last_bit  = (bit_cnt == nbits_i - CNT_W'(1));
    rx_next   = {rx_sh, mosi_s_i};
    len_mask  = {MAX_BITS{1'b1}} >> (CNT_W'(MAX_BITS) - nbits_i);
    rx_word_o = rx_next & len_mask;
    rx_load_o = ev_i.capture & last_bit;
    tx_copy_o = ev_i.sel_fall | rx_load_o;
    miso_o    = tx_sh[IDX_W'(nbits_i - CNT_W'(1))];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (nss_s_i) begin
      bit_cnt <= '0;  // partial word dropped
    end else if (ev_i.sel_fall) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (ev_i.capture) begin
      if (last_bit) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
      end else begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        rx_sh   <= rx_next[MAX_BITS-2:0];
      end
    end
  end

  // first change edge of a word keeps the freshly loaded MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '0;
    end else if (tx_copy_o) begin
      tx_sh <= tx_hold_i;
    end else if (ev_i.change && (bit_cnt != '0)) begin
      tx_sh <= {tx_sh[MAX_BITS-2:0], 1'b0};
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nss_s_i |=> (bit_cnt == '0)); // R8
  AST_LOAD_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_o |-> !nss_s_i); // R2

endmodule

// File: rtl/spi_slv_flags.sv
module spi_slv_flags #(
  parameter int unsigned MAX_BITS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_wr_i,
  input  logic [MAX_BITS-1:0] tx_data_i,
  input  logic                tx_copy_i,
  input  logic                rx_load_i,
  input  logic [MAX_BITS-1:0] rx_word_i,
  input  logic                rx_rd_i,
  input  logic                ovr_clr_i,
  output logic [MAX_BITS-1:0] tx_hold_o,
  output logic                tx_empty_o,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_full_o,
  output logic                rx_ovr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold_o  <= '0;
      tx_empty_o <= 1'b1;
    end else begin
      if (tx_wr_i) tx_hold_o <= tx_data_i;
      if (tx_wr_i)        tx_empty_o <= 1'b0;  // write wins over copy
      else if (tx_copy_i) tx_empty_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
      rx_ovr_o  <= 1'b0;
    end else begin
      if (rx_load_i) rx_data_o <= rx_word_i;
      if (rx_load_i)    rx_full_o <= 1'b1;
      else if (rx_rd_i) rx_full_o <= 1'b0;
      if (rx_load_i && rx_full_o && !rx_rd_i) rx_ovr_o <= 1'b1;
      else if (ovr_clr_i)                     rx_ovr_o <= 1'b0;
    end
  end

  AST_FULL_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_i |=> rx_full_o); // R5
  AST_OVR_ON_UNREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_load_i && rx_full_o && !rx_rd_i) |=> rx_ovr_o); // R6
  AST_READ_NO_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !rx_ovr_o && !ovr_clr_i) |=> !rx_ovr_o); // R6
  AST_EMPTY_ON_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_copy_i && !tx_wr_i) |=> tx_empty_o); // R7

endmodule

// File: rtl/spi_slv_serdes.sv
module spi_slv_serdes
  import spi_slv_pkg::*;
#(
  parameter int unsigned MIN_BITS = 8,
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned CODE_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                nss_i,
  input  logic                mosi_i,
  output logic                miso_o,
  output logic                miso_oen_o,
  input  logic                cfg_cpol_i,
  input  logic                cfg_ncpha_i,
  input  logic [CODE_W-1:0]   cfg_bits_i,
  input  logic                tx_wr_i,
  input  logic [MAX_BITS-1:0] tx_data_i,
  output logic                tx_empty_o,
  input  logic                rx_rd_i,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_full_o,
  input  logic                ovr_clr_i,
  output logic                rx_ovr_o
);

  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);
  localparam int unsigned CODE_TOP = MAX_BITS - MIN_BITS;

  logic [2:0]          pins_s;
  logic                sck_s, nss_s, mosi_s;
  spi_edge_t           ev;
  logic [CNT_W-1:0]    nbits;
  logic [MAX_BITS-1:0] tx_hold, rx_word;
  logic                tx_copy, rx_load;

  spi_slv_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, nss_i, sck_i}),
    .q_o   (pins_s)
  );
  assign {mosi_s, nss_s, sck_s} = pins_s;

  // reserved codes saturate to the longest word
  always_comb begin
    if (32'(cfg_bits_i) > CODE_TOP) nbits = CNT_W'(MAX_BITS);
    else                            nbits = CNT_W'(MIN_BITS) + CNT_W'(cfg_bits_i);
  end

  spi_slv_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(sck_s),
    .nss_s_i(nss_s),
    .cpol_i (cfg_cpol_i),
    .ncpha_i(cfg_ncpha_i),
    .ev_o   (ev)
  );

  spi_slv_shift #(.MAX_BITS(MAX_BITS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nss_s_i  (nss_s),
    .mosi_s_i (mosi_s),
    .ev_i     (ev),
    .nbits_i  (nbits),
    .tx_hold_i(tx_hold),
    .miso_o   (miso_o),
    .tx_copy_o(tx_copy),
    .rx_load_o(rx_load),
    .rx_word_o(rx_word)
  );

  spi_slv_flags #(.MAX_BITS(MAX_BITS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_wr_i   (tx_wr_i),
    .tx_data_i (tx_data_i),
    .tx_copy_i (tx_copy),
    .rx_load_i (rx_load),
    .rx_word_i (rx_word),
    .rx_rd_i   (rx_rd_i),
    .ovr_clr_i (ovr_clr_i),
    .tx_hold_o (tx_hold),
    .tx_empty_o(tx_empty_o),
    .rx_data_o (rx_data_o),
    .rx_full_o (rx_full_o),
    .rx_ovr_o  (rx_ovr_o)
  );

  assign miso_oen_o = nss_s;

  AST_OEN_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oen_o |-> !rx_load); // R9
  AST_NO_COPY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nss_s |-> !tx_copy); // R2

endmodule

// File: tb/spi_slv_serdes_tb.sv
`timescale 1ns/1ps
module spi_slv_serdes_tb_top;

  localparam int H = 4;  // serial half period in system clocks

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0, nss_i = 1'b1, mosi_i = 1'b0;
  logic        miso_o, miso_oen_o;
  logic        cfg_cpol_i = 1'b0, cfg_ncpha_i = 1'b0;
  logic [3:0]  cfg_bits_i = 4'd0;
  logic        tx_wr_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic        tx_empty_o;
  logic        rx_rd_i = 1'b0;
  logic [15:0] rx_data_o;
  logic        rx_full_o;
  logic        ovr_clr_i = 1'b0;
  logic        rx_ovr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  spi_slv_serdes dut_i (.*);

  // {bits code, cpol, ncpha, mosi word, tx word}
  localparam logic [37:0] VECS [8] = '{
    {4'd0,  1'b0, 1'b1, 16'h00A5, 16'h003C},
    {4'd0,  1'b1, 1'b1, 16'h005A, 16'h00C3},
    {4'd0,  1'b0, 1'b0, 16'h0096, 16'h0069},
    {4'd0,  1'b1, 1'b0, 16'h00F0, 16'h000F},
    {4'd8,  1'b0, 1'b1, 16'hBEEF, 16'h1234},
    {4'd4,  1'b1, 1'b0, 16'h0ABC, 16'h0D5E},
    {4'd15, 1'b0, 1'b0, 16'h8001, 16'h7FFE},
    {4'd1,  1'b1, 1'b1, 16'h01A5, 16'h00B3}
  };

  function automatic int len_of(logic [3:0] code);
    return (code > 4'd8) ? 16 : 8 + int'(code);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic cap_wait(bit rd_pulse);
    for (int w = 0; w < H; w++) begin
      @(negedge clk_i);
      rx_rd_i = rd_pulse && (w == 1);
    end
    rx_rd_i = 1'b0;
  endtask

  task automatic tx_write(logic [15:0] d);
    @(negedge clk_i); tx_wr_i = 1'b1; tx_data_i = d;
    @(negedge clk_i); tx_wr_i = 1'b0;
  endtask

  task automatic rx_read();
    @(negedge clk_i); rx_rd_i = 1'b1;
    @(negedge clk_i); rx_rd_i = 1'b0;
  endtask

  task automatic xfer(int n, logic [15:0] mo, output logic [15:0] mi,
                      input bit keep_sel, input bit rd_at_end);
    if (nss_i) begin
      sck_i = cfg_cpol_i;
      clks(4);
      nss_i = 1'b0;
      clks(6);
    end
    mi = '0;
    for (int k = 0; k < n; k++) begin
      mosi_i = mo[n-1-k];
      clks(H);
      if (cfg_ncpha_i) mi = {mi[14:0], miso_o};
      sck_i = ~sck_i;
      if (cfg_ncpha_i) cap_wait(rd_at_end && k == n-1); else clks(H);
      if (!cfg_ncpha_i) mi = {mi[14:0], miso_o};
      sck_i = ~sck_i;
      if (!cfg_ncpha_i) cap_wait(rd_at_end && k == n-1);
    end
    clks(H);
    if (!keep_sel) begin
      nss_i = 1'b1;
      clks(6);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] mi, mi2;
    logic [15:0] mask;
    int n;
    clks(3);
    rst_ni = 1'b1;
    clks(3);

    // R1 reset state
    chk("R1 rx_full", 32'(rx_full_o), 32'd0);
    chk("R1 rx_ovr", 32'(rx_ovr_o), 32'd0);
    chk("R1 tx_empty", 32'(tx_empty_o), 32'd1);
    chk("R1 miso_oen", 32'(miso_oen_o), 32'd1);
    chk("R1 rx_data", 32'(rx_data_o), 32'd0);

    // table walk: R3 R4 R5 R7
    for (int v = 0; v < 8; v++) begin
      cfg_bits_i  = VECS[v][37:34];
      cfg_cpol_i  = VECS[v][33];
      cfg_ncpha_i = VECS[v][32];
      n    = len_of(cfg_bits_i);
      mask = 16'((32'd1 << n) - 1);
      tx_write(VECS[v][15:0]);
      chk("R7 empty cleared by write", 32'(tx_empty_o), 32'd0);
      xfer(n, VECS[v][31:16], mi, 1'b0, 1'b0);
      chk("R3 R4 rx word", 32'(rx_data_o), 32'(VECS[v][31:16] & mask));
      chk("R4 miso word", 32'(mi), 32'(VECS[v][15:0] & mask));
      chk("R5 rx_full set", 32'(rx_full_o), 32'd1);
      chk("R7 empty after copy", 32'(tx_empty_o), 32'd1);
      rx_read();
      chk("R5 rx_full cleared", 32'(rx_full_o), 32'd0);
      chk("R6 no overrun", 32'(rx_ovr_o), 32'd0);
    end

    cfg_bits_i = 4'd0; cfg_cpol_i = 1'b0; cfg_ncpha_i = 1'b1;

    // R2 edges ignored while deselected
    for (int i = 0; i < 20; i++) begin
      sck_i = ~sck_i; mosi_i = ~mosi_i; clks(H);
    end
    sck_i = 1'b0;
    clks(4);
    chk("R2 no word while deselected", 32'(rx_full_o), 32'd0);
    chk("R9 oen high deselected", 32'(miso_oen_o), 32'd1);
    tx_write(16'h00D2);
    xfer(8, 16'h0033, mi, 1'b0, 1'b0);
    chk("R2 clean word after ignored edges", 32'(rx_data_o), 32'h0033);
    chk("R2 miso after ignored edges", 32'(mi), 32'h00D2);
    rx_read();

    // R8 partial word dropped
    nss_i = 1'b0; clks(6);
    chk("R9 oen low selected", 32'(miso_oen_o), 32'd0);
    for (int k = 0; k < 3; k++) begin
      mosi_i = 1'b1; clks(H); sck_i = 1'b1; clks(H); sck_i = 1'b0;
    end
    clks(H);
    nss_i = 1'b1; clks(6);
    chk("R8 partial not stored", 32'(rx_full_o), 32'd0);
    xfer(8, 16'h0081, mi, 1'b0, 1'b0);
    chk("R8 counter restarted", 32'(rx_data_o), 32'h0081);
    rx_read();

    // R6 overrun without read
    xfer(8, 16'h0011, mi, 1'b0, 1'b0);
    xfer(8, 16'h0022, mi, 1'b0, 1'b0);
    chk("R6 overrun set", 32'(rx_ovr_o), 32'd1);
    chk("R6 newest word kept", 32'(rx_data_o), 32'h0022);
    @(negedge clk_i); ovr_clr_i = 1'b1;
    @(negedge clk_i); ovr_clr_i = 1'b0;
    chk("R6 overrun cleared", 32'(rx_ovr_o), 32'd0);
    chk("R6 full still set", 32'(rx_full_o), 32'd1);

    // R6 read coincides with load (unread word present)
    cfg_ncpha_i = 1'b0;
    xfer(8, 16'h0044, mi, 1'b0, 1'b1);
    chk("R6 coincident read keeps full", 32'(rx_full_o), 32'd1);
    chk("R6 coincident read no overrun", 32'(rx_ovr_o), 32'd0);
    chk("R6 coincident word", 32'(rx_data_o), 32'h0044);
    rx_read();

    // R10 back-to-back words, second tx written mid-word
    tx_write(16'h00A1);
    fork
      xfer(8, 16'h0055, mi, 1'b1, 1'b0);
      begin clks(30); tx_write(16'h004E); end
    join
    chk("R10 first miso", 32'(mi), 32'h00A1);
    chk("R10 first rx", 32'(rx_data_o), 32'h0055);
    rx_read();
    xfer(8, 16'h00CC, mi2, 1'b0, 1'b0);
    chk("R10 second miso", 32'(mi2), 32'h004E);
    chk("R10 second rx", 32'(rx_data_o), 32'h00CC);
    chk("R10 no overrun", 32'(rx_ovr_o), 32'd0);

    // R7 empty holding resends old contents
    rx_read();
    xfer(8, 16'h0000, mi, 1'b0, 1'b0);
    chk("R7 resend old holding", 32'(mi), 32'h004E);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule